// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Cascaded Prescalers

This block generates four independent pulse-width modulated outputs from one input clock. Software programs it through a small 32-bit register window. One shared control word holds a run bit and a two-bit clock-divide code for every channel. Four per-channel words each hold a period length and a high-time length, both counted in prescaled ticks.

Each channel divides the clock through up to three cascaded divide-by-8 stages. The divide code picks how many stages are in the path, giving a divide of 1, 8, 64 or 512. The channel counts ticks from zero up to the end of its period. Its output is high while the count is below the high-time value.

New period, high-time and divide settings written while a channel runs are held back until the current period ends, so the output never shows a partial period. Starting a channel clears its count and prescaler. Stopping a channel forces its output low and leaves the other channels untouched.

Top module: `pwm4_prescaled`

## Requirements
- R1: After reset every register reads 0 and all four outputs are low.
- R2: The control word is at offset 0x0. Bit ch (0..3) is the run bit of channel ch. Bits [2*ch+5:2*ch+4] hold that channel's divide code. Bits 31:12 are not stored and read 0. The config word of channel ch is at offset 0x4+4*ch, with the period in bits [15:0] and the high time in bits [31:16]. All 32 bits are stored. Every defined word reads back the last value written to it.
- R3: A write to any other offset changes no register and no output. This includes offsets that are not a multiple of 4 and word offsets above 0x10. A read of such an offset returns 0.
- R4: A channel's output stays low in the cycle after the control word takes its run bit. In the next cycle the channel starts at count 0, and its output is high if the high time is non-zero.
- R5: With divide code 0, a running channel repeats a period of P clock cycles, where P is the period field. The output is high for the first D cycles of each period, where D is the high-time field.
- R6: Divide codes 1, 2 and 3 make each tick last 8, 64 and 512 clock cycles. A period then lasts P*8, P*64 and P*512 cycles, with D ticks high. The divide code is taken from that channel's own field.
- R7: A period field of 0 gives a period of 65536 ticks.
- R8: A high time equal to or greater than the period field keeps the output high for as long as the channel runs. A high time of 0 keeps it low.
- R9: Period, high-time and divide values written while a channel runs take effect only at the first tick of the next period.
- R10: Clearing a channel's run bit drives that output low from the cycle after the control word changes. The other running channels keep their waveforms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and all channels |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe; the word is stored at the rising edge |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A register write lands at the rising edge where the strobe is sampled. Read-back is combinational, so the bench reads one time step after it drives the offset. A change to a run bit reaches the output one edge after the control word changes. The bench therefore checks the output at the falling edge right after the write (still unchanged) and at the following falling edge (changed).

Waveform checks count high samples at falling edges over a window that spans a whole number of periods. This makes the expected count exact whatever the phase. The check of held-back settings first finds the falling edge where count 0 is visible, from the output's rising edge. It then writes at a known count and checks the rest of the old period and the next period separately.

// File: rtl/pwm4_pkg.sv
`timescale 1ns/1ps
package pwm4_pkg;

    localparam int NUM_CH  = 4;   // channel count
    localparam int DATA_W  = 32;  // register width
    localparam int CNT_W   = 16;  // period / high-time counter width
    localparam int PSC_W   = 2;   // divide-code width per channel
    localparam int STAGE_W = 3;   // each divide stage is 2**STAGE_W
    localparam int NSTAGE  = (1 << PSC_W) - 1;

    typedef enum logic [PSC_W-1:0] {
        PSC_BYPASS = 2'd0,
        PSC_DIV8   = 2'd1,
        PSC_DIV64  = 2'd2,
        PSC_DIV512 = 2'd3
    } psc_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] tbase;
    } ch_cfg_t;

    typedef struct packed {
        psc_sel_e psc;
        ch_cfg_t  cfg;
    } ch_active_t;

    // control word: run bits first, then one divide code per channel
    function automatic int ctrl_width(int n);
        return n + PSC_W * n;
    endfunction

    function automatic int psc_lsb(int n, int ch);
        return n + PSC_W * ch;
    endfunction

endpackage

// File: rtl/pwm4_regs.sv
`timescale 1ns/1ps
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int AW = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [AW-1:0]                addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [ctrl_width(N)-1:0]     ctrl_q,
    output ch_cfg_t [N-1:0]              cfg_q
);
    localparam int CTRL_W = ctrl_width(N);
    localparam int IDX_W  = AW - 2;

    logic             aligned;
    logic [IDX_W-1:0] idx;

    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = addr[AW-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else if (wr && aligned) begin
            if (idx == '0)
                ctrl_q <= wdata[CTRL_W-1:0];
            for (int ch = 0; ch < N; ch++) begin
                if (idx == IDX_W'(ch + 1))
                    cfg_q[ch] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (idx == '0)
                rdata[CTRL_W-1:0] = ctrl_q;
            for (int ch = 0; ch < N; ch++) begin
                if (idx == IDX_W'(ch + 1))
                    rdata = cfg_q[ch];
            end
        end
    end

endmodule

// File: rtl/pwm4_prescaler.sv
`timescale 1ns/1ps
module pwm4_prescaler
    import pwm4_pkg::*;
#(
    parameter int SW = STAGE_W,
    parameter int NS = NSTAGE
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  psc_sel_e sel,
    output logic     tick
);
    localparam logic [SW-1:0] TOP = '1;

    logic [PSC_W-1:0] sel_bits;
    logic [SW-1:0]    stg_q [NS];
    logic [NS-1:0]    active;
    logic [NS-1:0]    at_top;
    logic [NS:0]      carry;   // carry[k]: every stage below k is at its top

    assign sel_bits = sel;

    always_comb begin
        carry[0] = 1'b1;
        for (int k = 0; k < NS; k++) begin
            active[k]    = (int'(sel_bits) > k);
            at_top[k]    = !active[k] || (stg_q[k] == TOP);
            carry[k + 1] = carry[k] && at_top[k];
        end
    end

    assign tick = carry[NS];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NS; k++) begin
            if (rst || clear)
                stg_q[k] <= '0;
            else if (active[k] && carry[k])
                stg_q[k] <= stg_q[k] + 1'b1;
        end
    end

endmodule

// File: rtl/pwm4_channel.sv
`timescale 1ns/1ps
module pwm4_channel
    import pwm4_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  psc_sel_e psc_new,
    input  ch_cfg_t  cfg_new,
    output logic     pwm_o
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    ch_active_t       act_q;
    logic             tick;
    logic             psc_clear;
    logic [CNT_W-1:0] last;
    logic             wrap;

    // period field 0 wraps to 16'hFFFF here, giving a 65536-tick period
    assign last      = act_q.cfg.tbase - CNT_W'(1);
    assign wrap      = (cnt_q == last);
    assign psc_clear = !(run_q && en);

    pwm4_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .clear (psc_clear),
        .sel   (act_q.psc),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            act_q <= '0;
        end else if (!en) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            act_q <= '{psc: psc_new, cfg: cfg_new};
        end else if (tick) begin
            if (wrap) begin
                cnt_q <= '0;
                act_q <= '{psc: psc_new, cfg: cfg_new};
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwm_o = run_q && (cnt_q < act_q.cfg.duty);

endmodule

// File: rtl/pwm4_prescaled.sv
`timescale 1ns/1ps
module pwm4_prescaled
    import pwm4_pkg::*;
#(
    parameter int NUM_CH_P = NUM_CH,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CH_P-1:0] pwm_out
);
    localparam int CTRL_W = ctrl_width(NUM_CH_P);

    logic [CTRL_W-1:0]      ctrl_q;
    ch_cfg_t [NUM_CH_P-1:0] cfg_q;

    pwm4_regs #(
        .N  (NUM_CH_P),
        .AW (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .cfg_q  (cfg_q)
    );

    for (genvar ch = 0; ch < NUM_CH_P; ch++) begin : g_ch
        psc_sel_e psc_sel;
        assign psc_sel = psc_sel_e'(ctrl_q[psc_lsb(NUM_CH_P, ch) +: PSC_W]);

        pwm4_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .en      (ctrl_q[ch]),
            .psc_new (psc_sel),
            .cfg_new (cfg_q[ch]),
            .pwm_o   (pwm_out[ch])
        );
    end

endmodule

// File: rtl/pwm4_checker.sv
`timescale 1ns/1ps
module pwm4_checker
    import pwm4_pkg::*;
#(
    parameter int N  = NUM_CH,
    parameter int AW = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [AW-1:0]            bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [ctrl_width(N)-1:0] ctrl_q,
    input logic [N*DATA_W-1:0]      cfg_flat,
    input logic [N-1:0]             pwm_out
);
    localparam int CTRL_W = ctrl_width(N);

    logic known_off;
    always_comb begin
        known_off = (bus_addr[1:0] == 2'b00) && (int'(bus_addr[AW-1:2]) <= N);
    end

    // R2: control write is stored
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == '0) |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

    // R3: writes to undefined offsets leave every register alone
    assert_undef_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !known_off) |=> ($stable(ctrl_q) && $stable(cfg_flat)));

    for (genvar ch = 0; ch < N; ch++) begin : g_chk
        // R2: config write is stored
        assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == AW'(4 + 4 * ch))
            |=> (cfg_flat[ch*DATA_W +: DATA_W] == $past(bus_wdata)));

        // R10: a stopped channel is low one cycle later
        assert_low_when_off_R10: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[ch] |=> !pwm_out[ch]);
    end

endmodule

bind pwm4_prescaled pwm4_checker #(
    .N  (NUM_CH_P),
    .AW (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .cfg_flat  (cfg_q),
    .pwm_out   (pwm_out)
);

// File: tb/pwm4_prescaled_bench.sv
`timescale 1ns/1ps
module pwm4_prescaled_bench;
    localparam int NCH = 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    int hi [NCH];

    always #5 clk = ~clk;

    pwm4_prescaled u_pwm4_prescaled (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic count_high(int n);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) hi[c] += int'(pwm_out[c]);
        end
    endtask

    function automatic logic [31:0] cfgw(int duty, int tb);
        return {duty[15:0], tb[15:0]};
    endfunction

    task automatic stop_all();
        @(negedge clk);
        wr(8'h00, 32'h0);
        @(negedge clk);
    endtask

    task automatic test_reset_r1();
        rd_chk("R1 ctrl", 8'h00, 32'h0);
        for (int c = 0; c < NCH; c++) rd_chk("R1 cfg", AW'(4 + 4 * c), 32'h0);
        chk("R1 outputs", 32'(pwm_out), 32'h0);
    endtask

    task automatic test_regs_r2();
        @(negedge clk);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl upper bits read 0", 8'h00, 32'h0000_0FFF);
        @(negedge clk);
        wr(8'h04, 32'h1234_5678);
        wr(8'h08, 32'h9ABC_DEF0);
        wr(8'h0C, 32'h0F0F_F0F0);
        wr(8'h10, 32'hCAFE_0001);
        rd_chk("R2 cfg0", 8'h04, 32'h1234_5678);
        rd_chk("R2 cfg1", 8'h08, 32'h9ABC_DEF0);
        rd_chk("R2 cfg2", 8'h0C, 32'h0F0F_F0F0);
        rd_chk("R2 cfg3", 8'h10, 32'hCAFE_0001);
        stop_all();
        rd_chk("R2 ctrl cleared", 8'h00, 32'h0);
    endtask

    task automatic test_undef_r3();
        @(negedge clk);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl unchanged", 8'h00, 32'h0);
        rd_chk("R3 cfg0 unchanged", 8'h04, 32'h1234_5678);
        rd_chk("R3 cfg3 unchanged", 8'h10, 32'hCAFE_0001);
        rd_chk("R3 read 0x14", 8'h14, 32'h0);
        rd_chk("R3 read 0x05", 8'h05, 32'h0);
        count_high(4);
        chk("R3 outputs stay low", 32'(hi[0] + hi[1] + hi[2] + hi[3]), 32'h0);
    endtask

    task automatic test_enable_r4();
        stop_all();
        wr(8'h04, cfgw(4, 10));
        wr(8'h00, 32'h1);
        chk("R4 low in cycle after run bit", 32'(pwm_out[0]), 32'h0);
        @(negedge clk);
        chk("R4 high at count 0", 32'(pwm_out[0]), 32'h1);
        count_high(9);
        chk("R4 first period high ticks", 32'(hi[0]), 32'd3);
        @(negedge clk);
        chk("R4 restart at period end", 32'(pwm_out[0]), 32'h1);
    endtask

    task automatic test_wave_r5();
        count_high(100);
        chk("R5 tb10 duty4", 32'(hi[0]), 32'd40);
        stop_all();
        wr(8'h04, cfgw(3, 7));
        wr(8'h00, 32'h1);
        count_high(70);
        chk("R5 tb7 duty3", 32'(hi[0]), 32'd30);
    endtask

    task automatic test_prescale_r6();
        stop_all();
        wr(8'h04, cfgw(1, 4));
        wr(8'h00, 32'h11);
        count_high(64);
        chk("R6 div8", 32'(hi[0]), 32'd16);
        stop_all();
        wr(8'h04, cfgw(1, 2));
        wr(8'h00, 32'h21);
        count_high(256);
        chk("R6 div64", 32'(hi[0]), 32'd128);
        stop_all();
        wr(8'h0C, cfgw(1, 2));
        wr(8'h00, 32'h304);
        count_high(1024);
        chk("R6 div512 on ch2", 32'(hi[2]), 32'd512);
        chk("R6 ch0 idle", 32'(hi[0]), 32'd0);
    endtask

    task automatic test_full_range_r7();
        stop_all();
        wr(8'h04, cfgw(3, 0));
        wr(8'h00, 32'h1);
        count_high(65536);
        chk("R7 period 0 is 65536", 32'(hi[0]), 32'd3);
    endtask

    task automatic test_extremes_r8();
        stop_all();
        wr(8'h08, cfgw(9, 5));
        wr(8'h0C, cfgw(6, 6));
        wr(8'h10, cfgw(0, 5));
        wr(8'h00, 32'hE);
        @(negedge clk);
        count_high(60);
        chk("R8 duty above period", 32'(hi[1]), 32'd60);
        chk("R8 duty equal period", 32'(hi[2]), 32'd60);
        chk("R8 duty zero", 32'(hi[3]), 32'd0);
    endtask

    task automatic test_shadow_r9();
        logic prev;
        logic found;
        stop_all();
        wr(8'h04, cfgw(2, 10));
        wr(8'h00, 32'h1);
        prev  = pwm_out[0];
        found = 1'b0;
        for (int i = 0; i < 40 && !found; i++) begin
            @(negedge clk);
            if (pwm_out[0] && !prev) found = 1'b1;
            prev = pwm_out[0];
        end
        chk("R9 found count 0", 32'(found), 32'h1);
        repeat (3) @(negedge clk);
        wr(8'h04, cfgw(8, 10));
        chk("R9 old duty kept at count 4", 32'(pwm_out[0]), 32'h0);
        count_high(5);
        chk("R9 rest of old period", 32'(hi[0]), 32'd0);
        count_high(10);
        chk("R9 new period", 32'(hi[0]), 32'd8);
    endtask

    task automatic test_stop_r10();
        stop_all();
        wr(8'h04, cfgw(2, 4));
        wr(8'h08, cfgw(3, 6));
        wr(8'h00, 32'h3);
        @(negedge clk);
        count_high(24);
        chk("R10 ch0 before stop", 32'(hi[0]), 32'd12);
        chk("R10 ch1 before stop", 32'(hi[1]), 32'd12);
        wr(8'h00, 32'h2);
        @(negedge clk);
        chk("R10 ch0 low after stop", 32'(pwm_out[0]), 32'h0);
        count_high(60);
        chk("R10 ch0 stays low", 32'(hi[0]), 32'd0);
        chk("R10 ch1 keeps running", 32'(hi[1]), 32'd30);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_r1();
        test_regs_r2();
        test_undef_r3();
        test_enable_r4();
        test_wave_r5();
        test_prescale_r6();
        test_full_range_r7();
        test_extremes_r8();
        test_shadow_r9();
        test_stop_r10();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule